// File: doc/BRIEF.md
# Refresh Request Scheduler with Bounded Postponement

This block tells a DRAM command sequencer when a refresh is owed. A free-running timer divides the retention period among the rows of the device. Each time one share of that period ends, the block adds one refresh to a small debt counter. The timer period in clock cycles is computed at elaboration from three parameters: the clock frequency, the retention time and the row count. A refresh request is shown for as long as the debt is nonzero. The sequencer pays one unit of debt with a single-cycle completion strobe each time it has issued a refresh command.

The sequencer may hold a refresh back while a data burst finishes, so the debt can grow. When the debt reaches a configured limit, the block raises an urgent flag. If a further interval ends at the limit and no completion arrives in that cycle, the block sets a sticky violation flag and the count stays at the limit. The block also keeps its own copy of the row that the device will refresh next. This copy steps by one on each refresh that is paid and wraps after the last row.

Top module: `dram_refresh_sched`

## Requirements
- R1: The interval is floor(CLK_HZ × RETENTION_US / (1,000,000 × ROWS)) clock cycles. After reset is released, the first debt increment happens on clock edge number INTERVAL, and a further increment happens every INTERVAL edges after that.
- R2: When an interval ends, the debt rises by one. An accepted completion strobe lowers it by one. If both happen in the same cycle, the debt is unchanged.
- R3: `ref_req` is high exactly while the debt is nonzero.
- R4: `ref_urgent` is high exactly while the debt equals MAX_POSTPONE.
- R5: If an interval ends while the debt equals MAX_POSTPONE and no completion is accepted in that cycle, `debt_error` goes high and stays high until reset, and the debt stays at MAX_POSTPONE. An interval end that coincides with a completion at the limit does not set the flag.
- R6: A completion strobe that arrives while the debt is zero is ignored. The debt and `next_row` are unchanged.
- R7: `next_row` rises by one on each accepted completion and wraps from ROWS-1 to 0. This holds for row counts that are not a power of two.
- R8: While reset is asserted, the debt, `ref_req`, `ref_urgent`, `debt_error` and `next_row` are all zero, and the interval timer starts again from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ref_done | input | 1 | Single-cycle strobe: the sequencer has issued one refresh |
| ref_req | output | 1 | At least one refresh is owed |
| ref_urgent | output | 1 | The debt has reached the postponement limit |
| debt_error | output | 1 | Sticky flag: an interval ended at the limit and was not paid |
| next_row | output | ROW_W | Row that the device will refresh next |
| pending | output | CNT_W | Current refresh debt |

## Verification
The bench runs two small configurations. One has eight rows, so its row counter is a power of two. The other has six rows and a fractional interval that the floor must round down; a wrong rounding would move the first request by a cycle. The bench also exercises the following corner cases, each named with the fault it would expose:
- A completion strobe while nothing is owed: a design that does not ignore it would wrap the debt below zero or move the row.
- A completion that lands in the same cycle as an interval end at the limit: a design that gets this wrong would flag an error that never happened.
- The first unpaid interval end at the limit: a design that mishandles it would let the counter overflow or fail to latch the violation.
- Long runs under several service patterns (always, every ninth cycle, in bursts): these catch an off-by-one in the row wrap.

// File: rtl/rfs_pkg.sv
package rfs_pkg;

   // Cycles per row refresh slot: floor(hz * us / (1e6 * rows)).
   function automatic longint unsigned calc_interval(input longint unsigned hz,
                                                     input longint unsigned ret_us,
                                                     input longint unsigned rows);
      return (hz * ret_us) / (64'd1000000 * rows);
   endfunction

   function automatic bit is_pow2(input longint unsigned v);
      return (v != 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/rfs_tick_gen.sv
module rfs_tick_gen #(
   parameter int unsigned INTERVAL = 8
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick
);
   localparam int unsigned TW = (INTERVAL > 1) ? $clog2(INTERVAL) : 1;
   localparam logic [TW-1:0] LAST = TW'(INTERVAL - 1);

   logic [TW-1:0] cnt;

   // Slot boundary: counter sits on its final value.
   assign tick = (cnt == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cnt <= '0;
      else if (tick) cnt <= '0;
      else           cnt <= cnt + TW'(1);
   end
endmodule

// File: rtl/rfs_debt_ctr.sv
module rfs_debt_ctr #(
   parameter int unsigned MAX_POSTPONE = 8,
   parameter int unsigned CNT_W        = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             done,
   output logic [CNT_W-1:0] pending,
   output logic             req,
   output logic             urgent,
   output logic             error,
   output logic             accept
);
   localparam logic [CNT_W-1:0] LIMIT = CNT_W'(MAX_POSTPONE);

   logic at_limit;

   assign at_limit = (pending == LIMIT);
   assign req      = (pending != '0);
   assign urgent   = at_limit;
   // A strobe only counts when something is owed.
   assign accept   = done && req;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pending <= '0;
         error   <= 1'b0;
      end else begin
         if (tick && !accept) begin
            if (at_limit) error   <= 1'b1;
            else          pending <= pending + CNT_W'(1);
         end else if (!tick && accept) begin
            pending <= pending - CNT_W'(1);
         end
      end
   end
endmodule

// File: rtl/rfs_row_ctr.sv
module rfs_row_ctr #(
   parameter int unsigned ROWS  = 8192,
   parameter int unsigned ROW_W = 13
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             advance,
   output logic [ROW_W-1:0] row
);
   localparam bit POW2 = rfs_pkg::is_pow2(ROWS);

   generate
      if (POW2) begin : g_wrap_natural
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       row <= '0;
            else if (advance) row <= row + ROW_W'(1);
         end
      end else begin : g_wrap_compare
         localparam logic [ROW_W-1:0] TOP = ROW_W'(ROWS - 1);
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       row <= '0;
            else if (advance) row <= (row == TOP) ? '0 : row + ROW_W'(1);
         end
      end
   endgenerate
endmodule

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched #(
   parameter longint unsigned CLK_HZ       = 800_000_000,
   parameter longint unsigned RETENTION_US = 64_000,
   parameter int unsigned     ROWS         = 8192,
   parameter int unsigned     MAX_POSTPONE = 8,
   parameter int unsigned     ROW_W        = (ROWS > 1) ? $clog2(ROWS) : 1,
   parameter int unsigned     CNT_W        = $clog2(MAX_POSTPONE + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ref_done,
   output logic             ref_req,
   output logic             ref_urgent,
   output logic             debt_error,
   output logic [ROW_W-1:0] next_row,
   output logic [CNT_W-1:0] pending
);
   localparam longint unsigned INTERVAL_L =
      rfs_pkg::calc_interval(CLK_HZ, RETENTION_US, longint'(ROWS));
   localparam int unsigned INTERVAL = int'(INTERVAL_L);

   generate
      if (ROWS < 2) begin : g_bad_rows
         $error("ROWS must be at least 2");
      end
      if (MAX_POSTPONE < 1) begin : g_bad_max
         $error("MAX_POSTPONE must be at least 1");
      end
      if (INTERVAL_L < 1 || INTERVAL_L > 64'hFFFF_FFFF) begin : g_bad_interval
         $error("refresh interval out of range");
      end
      if (ROW_W < $clog2(ROWS)) begin : g_bad_row_w
         $error("ROW_W too narrow for ROWS");
      end
      if (CNT_W < $clog2(MAX_POSTPONE + 1)) begin : g_bad_cnt_w
         $error("CNT_W too narrow for MAX_POSTPONE");
      end
   endgenerate

   logic tick;
   logic accept;

   rfs_tick_gen #(.INTERVAL(INTERVAL)) u_tick (
      .clk  (clk),
      .rst_n(rst_n),
      .tick (tick)
   );

   rfs_debt_ctr #(.MAX_POSTPONE(MAX_POSTPONE), .CNT_W(CNT_W)) u_debt (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick   (tick),
      .done   (ref_done),
      .pending(pending),
      .req    (ref_req),
      .urgent (ref_urgent),
      .error  (debt_error),
      .accept (accept)
   );

   rfs_row_ctr #(.ROWS(ROWS), .ROW_W(ROW_W)) u_row (
      .clk    (clk),
      .rst_n  (rst_n),
      .advance(accept),
      .row    (next_row)
   );
endmodule

// File: rtl/rfs_checker.sv
module rfs_checker #(
   parameter int unsigned ROWS         = 8192,
   parameter int unsigned MAX_POSTPONE = 8,
   parameter int unsigned ROW_W        = 13,
   parameter int unsigned CNT_W        = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             ref_done,
   input logic             ref_req,
   input logic             ref_urgent,
   input logic             debt_error,
   input logic [ROW_W-1:0] next_row,
   input logic [CNT_W-1:0] pending
);
   // R3
   req_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ref_req == (pending != '0));

   // R4
   urgent_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ref_urgent |-> (ref_req && int'(pending) == int'(MAX_POSTPONE)));

   // R5
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      int'(pending) <= int'(MAX_POSTPONE));

   // R5
   error_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      debt_error |=> debt_error);

   // R7
   row_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ref_done && ref_req) |=>
         int'(next_row) == ((int'($past(next_row)) + 1) % int'(ROWS)));

   // R6
   idle_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ref_done && !ref_req) |=> $stable(next_row));
endmodule

bind dram_refresh_sched rfs_checker #(
   .ROWS(ROWS), .MAX_POSTPONE(MAX_POSTPONE), .ROW_W(ROW_W), .CNT_W(CNT_W)
) u_rfs_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .ref_done  (ref_done),
   .ref_req   (ref_req),
   .ref_urgent(ref_urgent),
   .debt_error(debt_error),
   .next_row  (next_row),
   .pending   (pending)
);

// File: tb/tb_dram_refresh_sched.sv
`timescale 1ns/1ps

module rfs_bench_model #(
   parameter int INTERVAL = 8,
   parameter int ROWS     = 8,
   parameter int MAXP     = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic done,
   output int   pend,
   output int   row,
   output int   err
);
   int t;
   bit tk;
   bit acc;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         t = 0; pend = 0; row = 0; err = 0;
      end else begin
         tk  = (t == INTERVAL - 1);
         t   = tk ? 0 : t + 1;
         acc = done && (pend != 0);
         if (tk && !acc) begin
            if (pend == MAXP) err = 1;
            else              pend = pend + 1;
         end else if (!tk && acc) begin
            pend = pend - 1;
         end
         if (acc) row = (row + 1) % ROWS;
      end
   end
endmodule

module tb_dram_refresh_sched;
   // Config A: 1 MHz, 64 us, 8 rows -> 8 cycles. Config B: 6 rows -> floor(10.67) = 10.
   localparam longint unsigned HZ  = 1_000_000;
   localparam longint unsigned RET = 64;
   localparam int ROWS_A = 8, MAX_A = 4;
   localparam int ROWS_B = 6, MAX_B = 3;
   localparam int IVL_A = int'((HZ * RET) / (64'd1000000 * ROWS_A));
   localparam int IVL_B = int'((HZ * RET) / (64'd1000000 * ROWS_B));

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic done_a = 1'b0, done_b = 1'b0;
   logic req_a, urg_a, err_a, req_b, urg_b, err_b;
   logic [2:0] row_a, row_b;
   logic [2:0] pend_a;
   logic [1:0] pend_b;
   int m_pend_a, m_row_a, m_err_a, m_pend_b, m_row_b, m_err_b;

   int checks = 0, failures = 0, cyc = 0;
   bit finished = 0;

   always #2 clk = ~clk;

   dram_refresh_sched #(.CLK_HZ(HZ), .RETENTION_US(RET), .ROWS(ROWS_A), .MAX_POSTPONE(MAX_A)) dut (
      .clk(clk), .rst_n(rst_n), .ref_done(done_a), .ref_req(req_a), .ref_urgent(urg_a),
      .debt_error(err_a), .next_row(row_a), .pending(pend_a));

   dram_refresh_sched #(.CLK_HZ(HZ), .RETENTION_US(RET), .ROWS(ROWS_B), .MAX_POSTPONE(MAX_B)) dut_b (
      .clk(clk), .rst_n(rst_n), .ref_done(done_b), .ref_req(req_b), .ref_urgent(urg_b),
      .debt_error(err_b), .next_row(row_b), .pending(pend_b));

   rfs_bench_model #(.INTERVAL(IVL_A), .ROWS(ROWS_A), .MAXP(MAX_A)) mdl_a (
      .clk(clk), .rst_n(rst_n), .done(done_a), .pend(m_pend_a), .row(m_row_a), .err(m_err_a));
   rfs_bench_model #(.INTERVAL(IVL_B), .ROWS(ROWS_B), .MAXP(MAX_B)) mdl_b (
      .clk(clk), .rst_n(rst_n), .done(done_b), .pend(m_pend_b), .row(m_row_b), .err(m_err_b));

   task automatic check(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s cyc=%0d actual=%0d expected=%0d", tag, cyc, act, exp);
      end
   endtask

   task automatic compare_all();
      check("R2 pending A", int'(pend_a), m_pend_a);
      check("R3 req A", int'(req_a), int'(m_pend_a != 0));
      check("R4 urgent A", int'(urg_a), int'(m_pend_a == MAX_A));
      check("R5 error A", int'(err_a), m_err_a);
      check("R7 row A", int'(row_a), m_row_a);
      check("R2 pending B", int'(pend_b), m_pend_b);
      check("R3 req B", int'(req_b), int'(m_pend_b != 0));
      check("R4 urgent B", int'(urg_b), int'(m_pend_b == MAX_B));
      check("R5 error B", int'(err_b), m_err_b);
      check("R7 row B", int'(row_b), m_row_b);
   endtask

   task automatic step();
      @(posedge clk);
      cyc++;
      @(negedge clk);
      compare_all();
   endtask

   task automatic check_reset_state();
      check("R8 pending A", int'(pend_a), 0);
      check("R8 req/urg/err A", int'({req_a, urg_a, err_a}), 0);
      check("R8 row A", int'(row_a), 0);
      check("R8 pending B", int'(pend_b), 0);
      check("R8 req/urg/err B", int'({req_b, urg_b, err_b}), 0);
      check("R8 row B", int'(row_b), 0);
   endtask

   initial begin
      int first_a, first_b;
      repeat (3) @(negedge clk);
      check_reset_state();
      rst_n = 1'b1;
      cyc = 0;
      first_a = -1; first_b = -1;
      // R1 first request timing, R6 idle strobe
      for (int i = 0; i < 12; i++) begin
         if (i == 3) begin done_a = 1'b1; done_b = 1'b1; end
         step();
         done_a = 1'b0; done_b = 1'b0;
         if (i == 3) begin
            check("R6 idle strobe pending A", int'(pend_a), 0);
            check("R6 idle strobe row A", int'(row_a), 0);
            check("R6 idle strobe row B", int'(row_b), 0);
         end
         if (req_a && first_a < 0) first_a = cyc;
         if (req_b && first_b < 0) first_b = cyc;
      end
      check("R1 first request A", first_a, 8);
      check("R1 first request B", first_b, 10);
      // R5 coincident completion at the limit: edge 40 ends a slot in both
      while (cyc < 39) step();
      check("R4 urgent at limit A", int'(urg_a), 1);
      done_a = 1'b1; done_b = 1'b1;
      step();
      done_a = 1'b0; done_b = 1'b0;
      check("R5 no error on paid slot A", int'(err_a), 0);
      check("R5 no error on paid slot B", int'(err_b), 0);
      check("R5 debt held A", int'(pend_a), MAX_A);
      check("R7 row after one A", int'(row_a), 1);
      // R5 overflow: A next slot ends at edge 48, B at edge 50
      while (cyc < 48) step();
      check("R5 overflow flag A", int'(err_a), 1);
      check("R5 saturate A", int'(pend_a), MAX_A);
      while (cyc < 50) step();
      check("R5 overflow flag B", int'(err_b), 1);
      repeat (20) step();
      check("R5 sticky A", int'(err_a), 1);
      // R8 reset in mid-run
      rst_n = 1'b0;
      step();
      check_reset_state();
      rst_n = 1'b1;
      cyc = 0;
      // Serve every cycle (strobe also while idle and on slot edges)
      done_a = 1'b1; done_b = 1'b1;
      repeat (200) step();
      done_a = 1'b0; done_b = 1'b0;
      // Serve only while requested
      for (int i = 0; i < 200; i++) begin
         done_a = req_a; done_b = req_b;
         step();
      end
      // Slow service: every ninth cycle
      for (int i = 0; i < 400; i++) begin
         done_a = (i % 9 == 0); done_b = (i % 9 == 0);
         step();
      end
      rst_n = 1'b0; done_a = 1'b0; done_b = 1'b0;
      step();
      rst_n = 1'b1;
      // Bursty service: postpone, then pay back in bursts
      for (int i = 0; i < 400; i++) begin
         done_a = ((i % 40) >= 30); done_b = ((i % 48) >= 36);
         step();
      end
      done_a = 1'b0; done_b = 1'b0;
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      #(200000 * 4);
      if (!finished) begin
         failures++;
         $display("FAIL watchdog expired cyc=%0d actual=1 expected=0", cyc);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule